// File: doc/BRIEF.md
# Shared Endpoint Buffer Allocator

This block splits one shared 8192-byte packet memory among the endpoints of a USB device and tracks which packet buffers hold data. The memory array, the packet engine and any DMA sit outside. The block computes addresses and buffer status only. It serves sixteen endpoint slots. The slot index is `2*endpoint_number + direction`, with OUT = 0 and IN = 1. Slots 0 and 1 are the two control endpoints, which are fixed at 64 bytes each. Slots 2 to 15 are the data endpoints 1 to 7. An 8-byte set-up buffer always occupies bytes 0 to 7.

Software configures each data slot through a write port: an enable, a requested packet size and a double-buffer flag. The partition is recomputed combinationally from the stored settings. Space is handed out in slot order as a running sum that starts after the set-up buffer, and enabled slots that do not fit are left out. A producer commits packets into a slot and a consumer releases them. Full flags and separate producer and consumer toggles give ping-pong use of double-buffered slots.

For the slot picked by `sel_idx`, the block presents three things: the byte address where the producer writes next, the address where the consumer reads next, and the per-buffer length. It also presents a readiness flag for each side and a sticky overflow flag.

Top module: `ep_buf_alloc`

## Requirements
- R1: After reset, slot 0 is allocated at base 8 and slot 1 at base 72, each with length 64. All data slots are unallocated with length 0, and `overflow` is 0.
- R2: Allocated slots take space in increasing slot order. The first enabled data slot starts at byte 136. Each later allocated slot starts where the previous allocated one ends. An allocated slot takes its size once, or twice when it is double-buffered.
- R3: A disabled slot takes no memory. It shows `sel_alloc`=0, `sel_len`=0 and both ready flags 0. A commit to it has no effect.
- R4: A requested size of 0 is stored as 1. A size above 1024 is stored as 1024. Other sizes are kept as given.
- R5: On a double-buffered slot, the producer address and the consumer address are each `base + toggle*len`, where toggle is 0 or 1. Each side's toggle flips when that side commits or releases a packet.
- R6: An enabled slot whose buffers would end past byte 8192 is unallocated and takes no space. Later slots are still placed if they fit.
- R7: `overflow` becomes 1 on the clock edge after an enabled slot is left unallocated. It stays 1 until reset, even if the configuration later fits.
- R8: A commit marks the producer's current buffer full. A commit to a full buffer is ignored. A single-buffered slot stops being producer-ready after one commit and is ready again after one release.
- R9: The consumer always reads the oldest full buffer. A release of an empty buffer is ignored.
- R10: Configuration writes to slots 0 and 1 are ignored.
- R11: A configuration write to a data slot empties both of its buffers and returns both of its toggles to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Slot index of the configuration write |
| cfg_en | input | 1 | Enable for the written slot |
| cfg_size | input | 16 | Requested packet size in bytes |
| cfg_dbl | input | 1 | Double-buffer flag for the written slot |
| prod_we | input | 1 | Producer commits one packet |
| prod_idx | input | 4 | Slot the producer commits to |
| cons_we | input | 1 | Consumer releases one packet |
| cons_idx | input | 4 | Slot the consumer releases |
| sel_idx | input | 4 | Slot shown on the outputs |
| sel_alloc | output | 1 | Selected slot holds memory |
| sel_len | output | 11 | Per-buffer length of the selected slot, 0 if unallocated |
| sel_prod_addr | output | 13 | Byte address of the producer's next buffer |
| sel_cons_addr | output | 13 | Byte address of the consumer's next buffer |
| sel_prod_ready | output | 1 | Producer's next buffer is empty and allocated |
| sel_cons_ready | output | 1 | Consumer's next buffer is full |
| overflow | output | 1 | Sticky: some enabled slot did not fit |

## Verification
The partition is combinational on registered settings, so a wrong offset appears on `sel_prod_addr` in the first cycle after the configuration write. Because bases are a running sum, the error spreads to every later slot. A stray full flag or toggle stays hidden until the producer or consumer touches that slot. It then shows up one cycle after the commit or release, as a wrong ready flag or an address that points at the other half of the pair. A missed overflow is seen one edge after the failing write, and an overflow that wrongly clears is seen at the next reconfiguration that fits.

// File: rtl/ep_alloc_pkg.sv
package ep_alloc_pkg;

  // Map a requested packet size onto the accepted range [1, maxp].
  function automatic logic [15:0] ep_clamp(input logic [15:0] req, input logic [15:0] maxp);
    if (req == 16'd0) return 16'd1;
    if (req > maxp)   return maxp;
    return req;
  endfunction

  // Bytes a slot asks for: nothing when off, one or two buffers otherwise.
  function automatic logic [31:0] ep_need(input logic en, input logic [15:0] len, input logic dbl);
    if (!en) return 32'd0;
    return dbl ? {15'd0, len, 1'b0} : {16'd0, len};
  endfunction

endpackage

// File: rtl/ep_alloc_map.sv
module ep_alloc_map
  import ep_alloc_pkg::*;
#(
  parameter int N_EP        = 16,
  parameter int MEM_BYTES   = 8192,
  parameter int SETUP_BYTES = 8,
  parameter int LW          = 11,
  parameter int AW          = 13
) (
  input  logic [N_EP-1:0]         en,
  input  logic [N_EP-1:0][LW-1:0] len,
  input  logic [N_EP-1:0]         dbl,
  output logic [N_EP-1:0][AW-1:0] base,
  output logic [N_EP-1:0]         alloc,
  output logic                    fit_fail
);

  logic [31:0] run;
  logic [31:0] need;

  always_comb begin
    run      = 32'(SETUP_BYTES);
    need     = '0;
    fit_fail = 1'b0;
    base     = '0;
    alloc    = '0;
    for (int i = 0; i < N_EP; i++) begin
      need = ep_need(en[i], 16'(len[i]), dbl[i]);
      if (en[i] && (run + need <= 32'(MEM_BYTES))) begin
        alloc[i] = 1'b1;
        base[i]  = run[AW-1:0];
        run      = run + need;
      end else if (en[i]) begin
        fit_fail = 1'b1;
      end
    end
  end

endmodule

// File: rtl/ep_buf_state.sv
module ep_buf_state #(
  parameter int N_EP = 16,
  parameter int IW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_EP-1:0] cfg_hit,
  input  logic [N_EP-1:0] alloc,
  input  logic [N_EP-1:0] dbl,
  input  logic            prod_we,
  input  logic [IW-1:0]   prod_idx,
  input  logic            cons_we,
  input  logic [IW-1:0]   cons_idx,
  output logic [N_EP-1:0] ptog,
  output logic [N_EP-1:0] ctog,
  output logic [N_EP-1:0] prod_rdy,
  output logic [N_EP-1:0] cons_rdy,
  output logic [N_EP-1:0] commit_ev,
  output logic [N_EP-1:0] release_ev
);

  for (genvar i = 0; i < N_EP; i++) begin : g_slot
    logic [1:0] full_q;

    assign prod_rdy[i]   = alloc[i] && !full_q[ptog[i]];
    assign cons_rdy[i]   = full_q[ctog[i]];
    assign commit_ev[i]  = prod_we && (prod_idx == IW'(i)) && prod_rdy[i] && !cfg_hit[i];
    assign release_ev[i] = cons_we && (cons_idx == IW'(i)) && cons_rdy[i] && !cfg_hit[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        full_q  <= 2'b00;
        ptog[i] <= 1'b0;
        ctog[i] <= 1'b0;
      end else if (cfg_hit[i]) begin
        full_q  <= 2'b00;
        ptog[i] <= 1'b0;
        ctog[i] <= 1'b0;
      end else begin
        if (commit_ev[i]) begin
          full_q[ptog[i]] <= 1'b1;
          if (dbl[i]) ptog[i] <= ~ptog[i];
        end
        if (release_ev[i]) begin
          full_q[ctog[i]] <= 1'b0;
          if (dbl[i]) ctog[i] <= ~ctog[i];
        end
      end
    end
  end

endmodule

// File: rtl/ep_buf_alloc.sv
module ep_buf_alloc
  import ep_alloc_pkg::*;
#(
  parameter int DATA_EPS    = 7,
  parameter int MEM_BYTES   = 8192,
  parameter int MAX_PKT     = 1024,
  parameter int CTRL_PKT    = 64,
  parameter int SETUP_BYTES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [3:0]  cfg_idx,
  input  logic        cfg_en,
  input  logic [15:0] cfg_size,
  input  logic        cfg_dbl,
  input  logic        prod_we,
  input  logic [3:0]  prod_idx,
  input  logic        cons_we,
  input  logic [3:0]  cons_idx,
  input  logic [3:0]  sel_idx,
  output logic        sel_alloc,
  output logic [10:0] sel_len,
  output logic [12:0] sel_prod_addr,
  output logic [12:0] sel_cons_addr,
  output logic        sel_prod_ready,
  output logic        sel_cons_ready,
  output logic        overflow
);

  localparam int N_EP = 2 * (DATA_EPS + 1);
  localparam int IW   = $clog2(N_EP);
  localparam int AW   = $clog2(MEM_BYTES);
  localparam int LW   = $clog2(MAX_PKT) + 1;

  logic [N_EP-1:0]         en_q, dbl_q;
  logic [N_EP-1:0][LW-1:0] len_q;
  logic [N_EP-1:0][AW-1:0] base;
  logic [N_EP-1:0]         alloc, ptog, ctog, prod_rdy, cons_rdy;
  logic [N_EP-1:0]         cfg_hit, commit_ev, release_ev;
  logic                    fit_fail;
  logic                    ovf_q;

  // Only data slots accept configuration writes.
  always_comb begin
    cfg_hit = '0;
    for (int i = 2; i < N_EP; i++)
      cfg_hit[i] = cfg_we && (cfg_idx == IW'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= {{(N_EP-2){1'b0}}, 2'b11};
      dbl_q <= '0;
      len_q <= '0;
      len_q[0] <= LW'(CTRL_PKT);
      len_q[1] <= LW'(CTRL_PKT);
    end else begin
      for (int i = 2; i < N_EP; i++) begin
        if (cfg_hit[i]) begin
          en_q[i]  <= cfg_en;
          dbl_q[i] <= cfg_dbl;
          len_q[i] <= LW'(ep_clamp(cfg_size, 16'(MAX_PKT)));
        end
      end
    end
  end

  ep_alloc_map #(
    .N_EP(N_EP), .MEM_BYTES(MEM_BYTES), .SETUP_BYTES(SETUP_BYTES), .LW(LW), .AW(AW)
  ) u_map (
    .en(en_q), .len(len_q), .dbl(dbl_q),
    .base(base), .alloc(alloc), .fit_fail(fit_fail)
  );

  ep_buf_state #(.N_EP(N_EP), .IW(IW)) u_state (
    .clk(clk), .rst_n(rst_n), .cfg_hit(cfg_hit), .alloc(alloc), .dbl(dbl_q),
    .prod_we(prod_we), .prod_idx(prod_idx), .cons_we(cons_we), .cons_idx(cons_idx),
    .ptog(ptog), .ctog(ctog), .prod_rdy(prod_rdy), .cons_rdy(cons_rdy),
    .commit_ev(commit_ev), .release_ev(release_ev)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ovf_q | fit_fail;
  end

  logic [LW-1:0] sel_len_raw;
  assign sel_len_raw    = len_q[sel_idx];
  assign sel_alloc      = alloc[sel_idx];
  assign sel_len        = sel_alloc ? sel_len_raw : '0;
  assign sel_prod_addr  = base[sel_idx] + (ptog[sel_idx] ? AW'(sel_len_raw) : '0);
  assign sel_cons_addr  = base[sel_idx] + (ctog[sel_idx] ? AW'(sel_len_raw) : '0);
  assign sel_prod_ready = prod_rdy[sel_idx];
  assign sel_cons_ready = cons_rdy[sel_idx];
  assign overflow       = ovf_q;

endmodule

// File: rtl/ep_buf_alloc_chk.sv
module ep_buf_alloc_chk #(
  parameter int MEM_BYTES = 8192,
  parameter int MAX_PKT   = 1024,
  parameter int CTRL_PKT  = 64
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic        prod_we,
  input logic [3:0]  prod_idx,
  input logic        cons_we,
  input logic [3:0]  sel_idx,
  input logic        sel_alloc,
  input logic [10:0] sel_len,
  input logic [12:0] sel_prod_addr,
  input logic [12:0] sel_cons_addr,
  input logic        sel_prod_ready,
  input logic        sel_cons_ready,
  input logic        overflow
);

  p_ctrl_fixed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_idx < 4'd2) |-> (sel_alloc && sel_len == 11'(CTRL_PKT)));

  p_len_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sel_alloc |-> (sel_len >= 11'd1 && 32'(sel_len) <= 32'(MAX_PKT)));

  p_fits_memory_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sel_alloc |-> (32'(sel_prod_addr) + 32'(sel_len) <= 32'(MEM_BYTES) &&
                   32'(sel_cons_addr) + 32'(sel_len) <= 32'(MEM_BYTES)));

  p_unalloc_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_alloc |-> (!sel_prod_ready && !sel_cons_ready && sel_len == 11'd0));

  p_overflow_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // A commit into a buffer that is not ready must leave the producer blocked (R8).
  p_full_commit_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (prod_we && prod_idx == sel_idx && !sel_prod_ready && !cfg_we && !cons_we)
      |=> (sel_idx != $past(sel_idx)) || !sel_prod_ready);

endmodule

bind ep_buf_alloc ep_buf_alloc_chk #(
  .MEM_BYTES(MEM_BYTES), .MAX_PKT(MAX_PKT), .CTRL_PKT(CTRL_PKT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .prod_we(prod_we), .prod_idx(prod_idx),
  .cons_we(cons_we), .sel_idx(sel_idx), .sel_alloc(sel_alloc), .sel_len(sel_len),
  .sel_prod_addr(sel_prod_addr), .sel_cons_addr(sel_cons_addr),
  .sel_prod_ready(sel_prod_ready), .sel_cons_ready(sel_cons_ready), .overflow(overflow)
);

// File: tb/ep_buf_alloc_test.sv
module ep_buf_alloc_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_en = 1'b0, cfg_dbl = 1'b0;
  logic [3:0] cfg_idx = '0, prod_idx = '0, cons_idx = '0, sel_idx = '0;
  logic [15:0] cfg_size = '0;
  logic prod_we = 1'b0, cons_we = 1'b0;
  logic sel_alloc, sel_prod_ready, sel_cons_ready, overflow;
  logic [10:0] sel_len;
  logic [12:0] sel_prod_addr, sel_cons_addr;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;

  // Bench-side record of the configuration (R2, R4).
  bit m_en[16];
  int m_len[16];
  bit m_dbl[16];

  always #(CLK_PERIOD/2) clk = ~clk;

  ep_buf_alloc uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en),
    .cfg_size(cfg_size), .cfg_dbl(cfg_dbl), .prod_we(prod_we), .prod_idx(prod_idx),
    .cons_we(cons_we), .cons_idx(cons_idx), .sel_idx(sel_idx), .sel_alloc(sel_alloc),
    .sel_len(sel_len), .sel_prod_addr(sel_prod_addr), .sel_cons_addr(sel_cons_addr),
    .sel_prod_ready(sel_prod_ready), .sel_cons_ready(sel_cons_ready), .overflow(overflow)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_eq(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  // Placement walk written over the bench's own record: returns base, or -1 if left out.
  function automatic int exp_base(input int idx);
    int pos = 8;
    for (int i = 0; i < 16; i++) begin
      int sz = m_en[i] ? m_len[i] * (m_dbl[i] ? 2 : 1) : 0;
      bit fits = m_en[i] && (pos + sz <= 8192);
      if (i == idx) return fits ? pos : -1;
      if (fits) pos += sz;
    end
    return -1;
  endfunction

  task automatic cfg_write(input int idx, input bit en, input int size, input bit dbl);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_en = en; cfg_size = 16'(size); cfg_dbl = dbl;
    @(negedge clk);
    cfg_we = 1'b0;
    if (idx >= 2) begin
      m_en[idx] = en; m_dbl[idx] = dbl;
      m_len[idx] = (size == 0) ? 1 : (size > 1024 ? 1024 : size);
    end
  endtask

  task automatic commit(input int idx);
    @(negedge clk); prod_we = 1'b1; prod_idx = 4'(idx);
    @(negedge clk); prod_we = 1'b0;
  endtask

  task automatic release_pkt(input int idx);
    @(negedge clk); cons_we = 1'b1; cons_idx = 4'(idx);
    @(negedge clk); cons_we = 1'b0;
  endtask

  task automatic clear_all();
    for (int i = 2; i < 16; i++) cfg_write(i, 1'b0, 1, 1'b0);
  endtask

  task automatic check_slot(input string req, input int idx);
    int b;
    sel_idx = 4'(idx);
    #1;
    b = exp_base(idx);
    check_eq(req, int'(sel_alloc), (b >= 0) ? 1 : 0);
    if (b >= 0) begin
      check_eq(req, int'(sel_prod_addr), b);
      check_eq(req, int'(sel_len), m_len[idx]);
    end else begin
      check_eq(req, int'(sel_len), 0);
    end
  endtask

  task automatic t_reset();
    check_slot("R1 ctrl out", 0);
    check_eq("R1 ctrl out base", int'(sel_prod_addr), 8);
    check_slot("R1 ctrl in", 1);
    check_eq("R1 ctrl in base", int'(sel_prod_addr), 72);
    check_slot("R1 data off", 9);
    check_eq("R1 overflow", int'(overflow), 0);
  endtask

  task automatic t_layout();
    cfg_write(2, 1'b1, 512, 1'b0);
    cfg_write(4, 1'b1, 100, 1'b1);
    cfg_write(15, 1'b1, 64, 1'b0);
    check_slot("R2 ep1 out", 2);
    check_eq("R2 first data base", int'(sel_prod_addr), 136);
    check_slot("R2 ep2 out", 4);
    check_eq("R2 ep2 base", int'(sel_prod_addr), 648);
    check_slot("R2 ep7 in", 15);
    check_eq("R2 ep7 base", int'(sel_prod_addr), 848);
    check_slot("R3 ep1 in off", 3);
    check_eq("R3 ready off", int'(sel_prod_ready), 0);
    commit(3);
    sel_idx = 4'd3; #1;
    check_eq("R3 commit ignored", int'(sel_cons_ready), 0);
  endtask

  task automatic t_clamp();
    cfg_write(5, 1'b1, 3000, 1'b0);
    check_slot("R4 clamp high", 5);
    check_eq("R4 len 1024", int'(sel_len), 1024);
    cfg_write(5, 1'b1, 0, 1'b0);
    check_slot("R4 clamp zero", 5);
    check_eq("R4 len 1", int'(sel_len), 1);
  endtask

  task automatic t_ctrl_ignored();
    cfg_write(0, 1'b0, 8, 1'b1);
    cfg_write(1, 1'b1, 900, 1'b0);
    check_slot("R10 ctrl out kept", 0);
    check_eq("R10 ctrl out len", int'(sel_len), 64);
    check_slot("R10 ctrl in kept", 1);
    check_eq("R10 ctrl in base", int'(sel_prod_addr), 72);
  endtask

  task automatic t_pingpong();
    clear_all();
    cfg_write(2, 1'b1, 100, 1'b1);
    sel_idx = 4'd2; #1;
    check_eq("R5 prod addr 0", int'(sel_prod_addr), 136);
    check_eq("R5 prod ready", int'(sel_prod_ready), 1);
    commit(2); #1;
    check_eq("R5 prod addr 1", int'(sel_prod_addr), 236);
    check_eq("R9 cons ready", int'(sel_cons_ready), 1);
    check_eq("R9 cons addr oldest", int'(sel_cons_addr), 136);
    commit(2); #1;
    check_eq("R8 both full", int'(sel_prod_ready), 0);
    commit(2); #1;
    check_eq("R8 extra commit ignored", int'(sel_prod_ready), 0);
    check_eq("R9 cons still oldest", int'(sel_cons_addr), 136);
    release_pkt(2); #1;
    check_eq("R9 cons next", int'(sel_cons_addr), 236);
    check_eq("R5 prod back to 0", int'(sel_prod_addr), 136);
    check_eq("R8 prod ready again", int'(sel_prod_ready), 1);
    release_pkt(2); #1;
    check_eq("R9 all empty", int'(sel_cons_ready), 0);
    release_pkt(2); #1;
    check_eq("R9 empty release ignored", int'(sel_cons_addr), 136);
  endtask

  task automatic t_single_and_clear();
    cfg_write(3, 1'b1, 50, 1'b0);
    sel_idx = 4'd3; #1;
    commit(3); #1;
    check_eq("R8 single full", int'(sel_prod_ready), 0);
    check_eq("R8 single addr fixed", int'(sel_prod_addr), exp_base(3));
    release_pkt(3); #1;
    check_eq("R8 single free", int'(sel_prod_ready), 1);
    check_eq("R8 single cons empty", int'(sel_cons_ready), 0);
    commit(3);
    cfg_write(3, 1'b1, 50, 1'b0); #1;
    check_eq("R11 cleared prod", int'(sel_prod_ready), 1);
    check_eq("R11 cleared cons", int'(sel_cons_ready), 0);
    cfg_write(2, 1'b1, 100, 1'b1);
    commit(2);
    cfg_write(2, 1'b1, 100, 1'b1);
    sel_idx = 4'd2; #1;
    check_eq("R11 toggle reset", int'(sel_prod_addr), 136);
  endtask

  task automatic t_overflow();
    clear_all();
    check_eq("R7 no overflow yet", int'(overflow), 0);
    for (int i = 2; i < 6; i++) cfg_write(i, 1'b1, 1024, 1'b1);
    cfg_write(6, 1'b1, 64, 1'b0);
    check_slot("R6 slot 5 left out", 5);
    check_slot("R6 slot 6 placed", 6);
    check_eq("R6 slot 6 base", int'(sel_prod_addr), 6280);
    @(negedge clk); #1;
    check_eq("R7 overflow set", int'(overflow), 1);
    cfg_write(5, 1'b0, 1, 1'b0);
    @(negedge clk); #1;
    check_eq("R7 overflow sticky", int'(overflow), 1);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      m_en[i] = (i < 2); m_len[i] = (i < 2) ? 64 : 0; m_dbl[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_layout();
    t_clamp();
    t_ctrl_ignored();
    t_pingpong();
    t_single_and_clear();
    t_overflow();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule